// File: doc/BRIEF.md
# Parallel Memory Bus Front End

This block sits behind the pins of an asynchronous parallel memory. It turns the active-low chip enable, output enable, write enable and device reset pins into one bus operation: read, write, standby, output disable or reset. It latches the address when chip enable falls. It drives or releases the data pins through a per-bit output enable. It holds a small internal word array that reads return and writes update.

A width pin picks 16-bit word mode or 8-bit byte mode. In byte mode only the low eight data pins carry data. The upper pins, except the top one, are released. The top data pin becomes the least significant address bit and picks the low or high byte of the addressed word.

At the end of each write cycle the block passes the captured address and data to a downstream command stage with a one-cycle strobe. All pins are sampled on the system clock.

Top module: `bus_op_front`

## Requirements
- R1: `bus_op` decodes the pins in this priority order. `hw_rst_n` low gives 4 (reset). Otherwise `ce_n` high gives 0 (standby). Otherwise `oe_n` low with `we_n` high gives 1 (read). Otherwise `oe_n` high with `we_n` low gives 2 (write). Every remaining combination gives 3 (output disable).
- R2: During a read in word mode (`word_mode` = 1), `dq_oe` is 16'hFFFF and `dq_out` is the array word at the latched address.
- R3: Whenever `bus_op` is not read, `dq_oe` is zero. This covers standby, output disable, write and reset, so the block never drives while `we_n` is low.
- R4: The address is latched at the first clock where `ce_n` is seen low after being high. It is held while `ce_n` stays low, even if `addr` changes.
- R5: In byte mode (`word_mode` = 0), a read gives `dq_oe` = 16'h00FF. `dq_out[15:8]` is zero and `dq_out[7:0]` is one byte of the latched word. The byte select is `dq_in[15]`, latched together with the address: 0 picks bits 7:0 and 1 picks bits 15:8.
- R6: While `bus_op` is write, the data on `dq_in` is sampled on each clock. In byte mode only `dq_in[7:0]` is kept. In the first clock after the write decode ends, `cmd_stb` pulses for exactly one cycle. With it, `cmd_data` holds the last sampled data and `cmd_addr` holds {latched address, byte select}. The byte select is 0 in word mode.
- R7: The same write end stores the data into the array. In word mode the whole word is written. In byte mode only the selected byte is written.
- R8: Pulling `hw_rst_n` low gives reset with `dq_oe` zero. It cancels a write in progress, so no strobe is issued and the array is left unchanged. After release, with `ce_n` low, the current address is latched again and array reads resume with no command needed.
- R9: `rst_n` low clears the array to zero and clears `cmd_stb`, `cmd_addr` and `cmd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the pins |
| rst_n | input | 1 | Active-low system reset, asynchronous |
| ce_n | input | 1 | Chip enable pin, active low |
| oe_n | input | 1 | Output enable pin, active low |
| we_n | input | 1 | Write enable pin, active low |
| hw_rst_n | input | 1 | Device reset pin, active low |
| word_mode | input | 1 | 1 = 16-bit word mode, 0 = 8-bit byte mode |
| addr | input | AW | Word address pins |
| dq_in | input | DW | Data pins as inputs; bit DW-1 is the byte select in byte mode |
| dq_out | output | DW | Data driven onto the pins |
| dq_oe | output | DW | Per-pin output enable |
| bus_op | output | 3 | Decoded bus operation |
| cmd_stb | output | 1 | One-cycle strobe at the end of a write |
| cmd_addr | output | AW+1 | Write address with byte select as LSB |
| cmd_data | output | DW | Write data captured for the command stage |

## Verification
The bench walks all sixteen combinations of the four control pins. A wrong priority would show up as a driven bus during a write, or as a read reported while chip enable is high.

Byte-mode reads check both halves of a word and the released upper pins. A swapped select would return the wrong byte, and a missing release would drive pins 15:8.

The bench also moves the address while chip enable stays low. A design that tracks the pins instead of latching them would return the new word.

Finally, the bench pulls the device reset in the middle of a write. A design that does not cancel the write would strobe and corrupt the array. It then releases reset with chip enable held low, where a design that does not re-latch would read a stale address.

// File: rtl/bus_op_front.sv
module bus_op_front #(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          hw_rst_n,
  input  logic          word_mode,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] dq_in,
  output logic [DW-1:0] dq_out,
  output logic [DW-1:0] dq_oe,
  output logic [2:0]    bus_op,
  output logic          cmd_stb,
  output logic [AW:0]   cmd_addr,
  output logic [DW-1:0] cmd_data
);

  localparam int HW = DW / 2;
  localparam logic [2:0] OP_STBY = 3'd0;
  localparam logic [2:0] OP_READ = 3'd1;
  localparam logic [2:0] OP_WRIT = 3'd2;
  localparam logic [2:0] OP_ODIS = 3'd3;
  localparam logic [2:0] OP_RST  = 3'd4;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] a_lat;
  logic          bsel_lat;
  logic          ce_q, wr_q, wm_q;
  logic [DW-1:0] wdat;
  logic [DW-1:0] rd_word;

  wire rst_act = !hw_rst_n;
  wire ce_fall = ce_q && !ce_n && !rst_act;
  wire wr_end  = wr_q && (bus_op != OP_WRIT) && !rst_act;

  always_comb begin
    if (rst_act)              bus_op = OP_RST;
    else if (ce_n)            bus_op = OP_STBY;
    else if (!oe_n && we_n)   bus_op = OP_READ;
    else if (oe_n && !we_n)   bus_op = OP_WRIT;
    else                      bus_op = OP_ODIS;
  end

  assign rd_word = mem[a_lat];
  assign dq_oe   = (bus_op != OP_READ) ? '0 :
                   word_mode ? '1 : {{HW{1'b0}}, {HW{1'b1}}};
  assign dq_out  = word_mode ? rd_word :
                   {{HW{1'b0}}, bsel_lat ? rd_word[DW-1:HW] : rd_word[HW-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q     <= 1'b1;
      wr_q     <= 1'b0;
      wm_q     <= 1'b1;
      a_lat    <= '0;
      bsel_lat <= 1'b0;
      wdat     <= '0;
      cmd_stb  <= 1'b0;
      cmd_addr <= '0;
      cmd_data <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      ce_q    <= ce_n | rst_act;
      wr_q    <= (bus_op == OP_WRIT);
      cmd_stb <= 1'b0;
      if (ce_fall) begin
        a_lat    <= addr;
        bsel_lat <= !word_mode && dq_in[DW-1];
      end
      if (bus_op == OP_WRIT) begin
        wdat <= word_mode ? dq_in : {{HW{1'b0}}, dq_in[HW-1:0]};
        wm_q <= word_mode;
      end
      if (wr_end) begin
        cmd_stb  <= 1'b1;
        cmd_addr <= {a_lat, bsel_lat};
        cmd_data <= wdat;
        if (wm_q)          mem[a_lat]         <= wdat;
        else if (bsel_lat) mem[a_lat][DW-1:HW] <= wdat[HW-1:0];
        else               mem[a_lat][HW-1:0]  <= wdat[HW-1:0];
      end
    end
  end

  // R3
  oe_we_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> dq_oe == '0);

  // R3
  standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n) |-> dq_oe == '0);

  // R8
  reset_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_rst_n |-> (dq_oe == '0 && bus_op == OP_RST));

  // R5
  byte_hi_z_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !word_mode |-> dq_oe[DW-1:HW] == '0);

  // R6
  stb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |=> !cmd_stb);

  // R6
  stb_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_stb) |-> $past(bus_op == OP_WRIT, 2));

endmodule

// File: tb/test_bus_op_front.sv
module test_bus_op_front;
  localparam int DW = 16;
  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH);

  logic clk = 0, rst_n = 0;
  logic ce_n = 1, oe_n = 1, we_n = 1, hw_rst_n = 1, word_mode = 1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dq_in = '0;
  logic [DW-1:0] dq_out, dq_oe, cmd_data;
  logic [2:0] bus_op;
  logic cmd_stb;
  logic [AW:0] cmd_addr;

  int checks = 0, fails = 0;
  logic [DW-1:0] model [DEPTH];

  always #2 clk = ~clk;

  bus_op_front #(.DW(DW), .DEPTH(DEPTH)) i_bus_op_front (
    .clk, .rst_n, .ce_n, .oe_n, .we_n, .hw_rst_n, .word_mode, .addr, .dq_in,
    .dq_out, .dq_oe, .bus_op, .cmd_stb, .cmd_addr, .cmd_data);

  // index = {hw_rst_n, ce_n, oe_n, we_n}
  localparam logic [2:0] EXP_OP [16] = '{
    3'd4, 3'd4, 3'd4, 3'd4, 3'd4, 3'd4, 3'd4, 3'd4,
    3'd3, 3'd1, 3'd2, 3'd3, 3'd0, 3'd0, 3'd0, 3'd0};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    ce_n = 1; oe_n = 1; we_n = 1; hw_rst_n = 1;
    @(negedge clk);
  endtask

  task automatic do_write(input logic wm, input logic [AW-1:0] a, input logic sel, input logic [DW-1:0] d);
    idle();
    word_mode = wm; addr = a; ce_n = 0;
    dq_in = wm ? '0 : {sel, {(DW-1){1'b0}}};
    @(negedge clk);
    we_n = 0;
    dq_in = wm ? d : {sel, 7'd0, d[7:0]};
    @(negedge clk);
    we_n = 1;
    @(negedge clk);
    chk("R6 stb", cmd_stb, 1);
    chk("R6 data", cmd_data, wm ? d : {8'd0, d[7:0]});
    chk("R6 addr", cmd_addr, {a, wm ? 1'b0 : sel});
    if (wm) model[a] = d;
    else if (sel) model[a][15:8] = d[7:0];
    else model[a][7:0] = d[7:0];
    ce_n = 1;
    @(negedge clk);
    chk("R6 one cycle", cmd_stb, 0);
  endtask

  task automatic do_read(input string req, input logic wm, input logic [AW-1:0] a, input logic sel);
    idle();
    word_mode = wm; addr = a; ce_n = 0; oe_n = 0;
    dq_in = wm ? '0 : {sel, {(DW-1){1'b0}}};
    @(negedge clk);
    if (wm) begin
      chk({req, " word data"}, dq_out, model[a]);
      chk({req, " word oe"}, dq_oe, 16'hFFFF);
    end else begin
      chk({req, " byte data"}, dq_out, {8'd0, sel ? model[a][15:8] : model[a][7:0]});
      chk({req, " byte oe"}, dq_oe, 16'h00FF);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    repeat (2) @(negedge clk);
    // R9 reset state
    chk("R9 stb", cmd_stb, 0);
    chk("R9 cmd_data", cmd_data, 0);
    chk("R3 oe idle", dq_oe, 0);
    chk("R1 idle op", bus_op, 0);
    rst_n = 1;
    @(negedge clk);

    // R1 R3 R2: walk the decode table
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      {hw_rst_n, ce_n, oe_n, we_n} = i[3:0];
      #1;
      chk("R1 decode", bus_op, EXP_OP[i]);
      chk("R3 oe per op", dq_oe, (EXP_OP[i] == 3'd1) ? 16'hFFFF : 16'h0000);
    end

    // R6 R7 word writes, R2 reads
    do_write(1, 4'd1, 0, 16'h1234);
    do_write(1, 4'd2, 0, 16'hBEEF);
    do_write(1, 4'd5, 0, 16'h0F0F);
    do_write(1, 4'd15, 0, 16'hC3A5);
    do_read("R2", 1, 4'd1, 0);
    do_read("R2", 1, 4'd2, 0);
    do_read("R2", 1, 4'd15, 0);

    // R5 byte reads
    do_read("R5 low", 0, 4'd2, 0);
    do_read("R5 high", 0, 4'd2, 1);
    do_read("R5 high", 0, 4'd15, 1);

    // R7 byte writes, both halves
    do_write(0, 4'd5, 1, 16'h00A5);
    do_read("R7 hi byte", 1, 4'd5, 0);
    do_write(0, 4'd5, 0, 16'h003C);
    do_read("R7 lo byte", 1, 4'd5, 0);

    // R4 address held while CE low
    do_read("R4 first", 1, 4'd1, 0);
    addr = 4'd2;
    @(negedge clk);
    @(negedge clk);
    chk("R4 held", dq_out, model[1]);

    // R8 reset pin during read, then release with CE low
    hw_rst_n = 0;
    #1;
    chk("R8 op", bus_op, 4);
    chk("R8 oe", dq_oe, 0);
    @(negedge clk);
    addr = 4'd15;
    hw_rst_n = 1;
    @(negedge clk);
    chk("R8 resume data", dq_out, model[15]);
    chk("R8 resume oe", dq_oe, 16'hFFFF);

    // R8 reset pin cancels a write
    idle();
    word_mode = 1; addr = 4'd2; ce_n = 0; dq_in = '0;
    @(negedge clk);
    we_n = 0; dq_in = 16'hDEAD;
    @(negedge clk);
    we_n = 1; hw_rst_n = 0;
    @(negedge clk);
    chk("R8 no stb", cmd_stb, 0);
    @(negedge clk);
    chk("R8 no stb later", cmd_stb, 0);
    do_read("R8 array kept", 1, 4'd2, 0);

    // R9 system reset clears the array
    idle();
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    do_read("R9 cleared", 1, 4'd1, 0);
    do_read("R9 cleared", 1, 4'd15, 0);

    idle();
    finish_up();
  end
endmodule